// File: doc/BRIEF.md
# Phase-Staggered Operation Issue Pipeline

The block issues wide instructions whose operations come already sorted into three groups: readers (which need no belt operands), compute operations, and writer/transfer operations. Each group issues in its own cycle, one after another. Three slots hold the in-flight instructions. In any cycle without a stall, the youngest instruction issues its reader group, the one before it issues its compute group, and the oldest issues its writer/transfer group. Producers therefore always issue ahead of their consumers. The pattern stays intact across branches whose outcome was predicted correctly.

Each accepted instruction gets a sequence tag from a wrapping counter. Every issue strobe carries this tag and the phase index, so downstream units can match the three parts of one instruction. A branch resolves in the last phase, from the predicted and actual direction bits carried with the instruction.

On a mispredict, the following happens in that same cycle:
- The writer group of the branching instruction still issues.
- The compute group of the next instruction is withheld.
- The reader results of the two younger, wrong-path instructions are cancelled by tag.

After that cycle comes one bubble cycle with no issue. The pipeline then refills from the corrected target, which the upstream front end presents.

Top module: `ph_stagger_issue`

## Requirements
- R1: After reset, all issue valids, the redirect and the cancel valids are low. The first instruction accepted after reset gets tag 0.
- R2: `in_take` is high exactly when `in_valid` is high, `stall` is low and `redirect` is low. An accepted instruction issues its reader group on phase index 0 in the next cycle, unless that cycle is stalled.
- R3: Without a stall, an instruction that issues phase p in cycle t issues phase p+1 in cycle t+1 with the same tag. Phase 1 (compute) is the one exception: it is withheld in a redirect cycle.
- R4: Accepted instructions get consecutive tags modulo 2^TAG_W. Tags of flushed instructions are not reused.
- R5: While `stall` is high, no issue valid and no `in_take` is asserted, and all slots hold their contents. Issue resumes unchanged after the stall ends.
- R6: A branch in the last phase whose predicted direction equals its actual direction causes no redirect and no disruption of the pattern.
- R7: A branch in the last phase with predicted direction different from the actual one asserts `redirect` in that cycle, unless stalled. The writer/transfer group of that instruction still issues in that cycle.
- R8: In a redirect cycle, phase index 1 is not issued. The phase-0 (reader) group still issues speculatively. `cxl_vld[0]` and `cxl_vld[1]` flag the occupied younger slots (phase 0 and phase 1 respectively) and carry their tags. Cancel valids are low in every other cycle.
- R9: The cycle after a redirect issues nothing. An instruction accepted in that bubble cycle issues its reader group in the cycle after.
- R10: `iss_ops[p]` carries the instruction's reader group for p=0, its compute group for p=1 and its writer group for p=2. It is all zeros whenever `iss_vld[p]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_rd_ops | input | OPS_W | Reader operation group |
| in_cp_ops | input | OPS_W | Compute operation group |
| in_wr_ops | input | OPS_W | Writer/transfer operation group |
| in_br_en | input | 1 | Instruction contains a branch |
| in_br_pred | input | 1 | Predicted branch direction |
| in_br_taken | input | 1 | Actual branch direction |
| stall | input | 1 | Freeze all slots |
| in_take | output | 1 | Offered instruction accepted this cycle |
| iss_vld | output | 3 | Issue strobe per phase index |
| iss_tag | output | 3 x TAG_W | Sequence tag per phase index |
| iss_ops | output | 3 x OPS_W | Issued operation group per phase index |
| redirect | output | 1 | Mispredict: flush the younger slots, refetch |
| cxl_vld | output | 2 | Cancel reader results of the younger slots |
| cxl_tag | output | 2 x TAG_W | Tags of the cancelled instructions |

## Verification
The bench builds the block with OPS_W=3 and TAG_W=3. Tags then wrap after eight instructions, so reuse and wrap of the sequence counter come up many times within a short run. Every 3-bit operation group value is also within reach. A pseudo-random sweep of several thousand cycles mixes stalls, gaps in the offered stream, and correct and wrong predictions. This covers back-to-back mispredicts, stalls landing on a branch in the last phase, and refills after a bubble. Each cycle is compared against a slot-level reference model.

// File: rtl/ph_pkg.sv
package ph_pkg;
    // number of staggered phase slots
    localparam int unsigned NPH = 3;

    typedef enum logic [1:0] {
        PH_READ    = 2'd0,
        PH_COMPUTE = 2'd1,
        PH_WRITE   = 2'd2
    } phase_e;

    // a branch is wrong when present and its guess differs from its outcome
    function automatic logic br_wrong(input logic en, input logic guess, input logic outcome);
        return en && (guess != outcome);
    endfunction
endpackage

// File: rtl/ph_slot.sv
module ph_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         clear,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!hold) begin
            q <= clear ? '0 : d;
        end
    end
endmodule

// File: rtl/ph_seq_ctr.sv
module ph_seq_ctr #(
    parameter int unsigned TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
        end else if (inc) begin
            tag <= tag + 1'b1;
        end
    end
endmodule

// File: rtl/ph_issue_ctl.sv
module ph_issue_ctl
    import ph_pkg::*;
(
    input  logic           stall,
    input  logic           in_valid,
    input  logic [NPH-1:0] slot_vld,
    input  logic           last_br_en,
    input  logic           last_br_pred,
    input  logic           last_br_taken,
    output logic           take,
    output logic           miss,
    output logic [NPH-1:0] vld,
    output logic [NPH-2:0] cxl
);
    localparam int unsigned LAST = int'(PH_WRITE);

    always_comb begin
        miss = slot_vld[LAST] && !stall && br_wrong(last_br_en, last_br_pred, last_br_taken);
        take = in_valid && !stall && !miss;
        for (int k = 0; k < NPH; k++) begin
            if (k == 0 || k == LAST) begin
                // speculative readers and committed writers always go
                vld[k] = slot_vld[k] && !stall;
            end else begin
                vld[k] = slot_vld[k] && !stall && !miss;
            end
        end
        for (int k = 0; k < NPH - 1; k++) begin
            cxl[k] = miss && slot_vld[k];
        end
    end
endmodule

// File: rtl/ph_stagger_issue.sv
module ph_stagger_issue
    import ph_pkg::*;
#(
    parameter int unsigned OPS_W = 4,
    parameter int unsigned TAG_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [OPS_W-1:0]           in_rd_ops,
    input  logic [OPS_W-1:0]           in_cp_ops,
    input  logic [OPS_W-1:0]           in_wr_ops,
    input  logic                       in_br_en,
    input  logic                       in_br_pred,
    input  logic                       in_br_taken,
    input  logic                       stall,
    output logic                       in_take,
    output logic [NPH-1:0]             iss_vld,
    output logic [NPH-1:0][TAG_W-1:0]  iss_tag,
    output logic [NPH-1:0][OPS_W-1:0]  iss_ops,
    output logic                       redirect,
    output logic [NPH-2:0]             cxl_vld,
    output logic [NPH-2:0][TAG_W-1:0]  cxl_tag
);
    // slot record layout: valid, op groups by phase, tag, branch bits
    localparam int unsigned OPS_LO = 1;
    localparam int unsigned TAG_LO = OPS_LO + NPH * OPS_W;
    localparam int unsigned BR_LO  = TAG_LO + TAG_W;
    localparam int unsigned REC_W  = BR_LO + 3;
    localparam int unsigned LAST   = int'(PH_WRITE);

    logic [REC_W-1:0] rec [NPH];
    logic [REC_W-1:0] new_rec;
    logic [TAG_W-1:0] seq;
    logic [NPH-1:0]   slot_vld;
    logic             miss;

    assign new_rec = {in_br_taken, in_br_pred, in_br_en, seq,
                      in_wr_ops, in_cp_ops, in_rd_ops, 1'b1};

    ph_seq_ctr #(.TAG_W(TAG_W)) i_seq (
        .clk (clk),
        .rst (rst),
        .inc (in_take),
        .tag (seq)
    );

    ph_issue_ctl i_ctl (
        .stall         (stall),
        .in_valid      (in_valid),
        .slot_vld      (slot_vld),
        .last_br_en    (rec[LAST][BR_LO]),
        .last_br_pred  (rec[LAST][BR_LO+1]),
        .last_br_taken (rec[LAST][BR_LO+2]),
        .take          (in_take),
        .miss          (miss),
        .vld           (iss_vld),
        .cxl           (cxl_vld)
    );

    assign redirect = miss;

    for (genvar k = 0; k < NPH; k++) begin : g_slot
        logic [REC_W-1:0] din;
        logic             clr;
        if (k == 0) begin : g_head
            assign din = new_rec;
            assign clr = !in_take;
        end else begin : g_tail
            assign din = rec[k-1];
            assign clr = miss;
        end
        ph_slot #(.W(REC_W)) i_slot (
            .clk   (clk),
            .rst   (rst),
            .hold  (stall),
            .clear (clr),
            .d     (din),
            .q     (rec[k])
        );
        assign slot_vld[k] = rec[k][0];
        assign iss_tag[k]  = rec[k][TAG_LO +: TAG_W];
        assign iss_ops[k]  = iss_vld[k] ? rec[k][OPS_LO + k*OPS_W +: OPS_W] : '0;
        if (k < NPH - 1) begin : g_cxl
            assign cxl_tag[k] = rec[k][TAG_LO +: TAG_W];
        end
    end
endmodule

// File: rtl/ph_stagger_issue_chk.sv
module ph_stagger_issue_chk
    import ph_pkg::*;
#(
    parameter int unsigned TAG_W = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      stall,
    input logic                      in_take,
    input logic [NPH-1:0]            iss_vld,
    input logic [NPH-1:0][TAG_W-1:0] iss_tag,
    input logic                      redirect,
    input logic [NPH-2:0]            cxl_vld
);
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
        stall |-> (iss_vld == '0 && !in_take)); // R5

    AST_STAGGER_TAG: assert property (@(posedge clk) disable iff (rst)
        (iss_vld[1] && $past(!stall && !redirect)) |-> ($past(iss_vld[0]) && iss_tag[1] == $past(iss_tag[0]))); // R3

    AST_TAKE_ISSUES: assert property (@(posedge clk) disable iff (rst)
        in_take |=> (iss_vld[0] || stall)); // R2

    AST_WRITER_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        redirect |-> iss_vld[NPH-1]); // R7

    AST_MIDDLE_HELD: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !iss_vld[1]); // R8

    AST_CANCEL_GATED: assert property (@(posedge clk) disable iff (rst)
        (|cxl_vld) |-> redirect); // R8

    AST_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (iss_vld == '0)); // R9

    AST_NO_TAKE_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !in_take); // R9
endmodule

bind ph_stagger_issue ph_stagger_issue_chk #(.TAG_W(TAG_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .in_take  (in_take),
    .iss_vld  (iss_vld),
    .iss_tag  (iss_tag),
    .redirect (redirect),
    .cxl_vld  (cxl_vld)
);

// File: tb/test_ph_stagger_issue.sv
`timescale 1ns/1ps
module test_ph_stagger_issue;
    localparam int OW = 3;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_br_en = 1'b0, in_br_pred = 1'b0, in_br_taken = 1'b0, stall = 1'b0;
    logic [OW-1:0] in_rd_ops = '0, in_cp_ops = '0, in_wr_ops = '0;
    logic in_take, redirect;
    logic [2:0] iss_vld;
    logic [2:0][TW-1:0] iss_tag;
    logic [2:0][OW-1:0] iss_ops;
    logic [1:0] cxl_vld;
    logic [1:0][TW-1:0] cxl_tag;

    always #5 clk = ~clk;

    ph_stagger_issue #(.OPS_W(OW), .TAG_W(TW)) i_ph_stagger_issue (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_rd_ops(in_rd_ops), .in_cp_ops(in_cp_ops), .in_wr_ops(in_wr_ops),
        .in_br_en(in_br_en), .in_br_pred(in_br_pred), .in_br_taken(in_br_taken),
        .stall(stall), .in_take(in_take), .iss_vld(iss_vld), .iss_tag(iss_tag),
        .iss_ops(iss_ops), .redirect(redirect), .cxl_vld(cxl_vld), .cxl_tag(cxl_tag)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference slot model, index = phase slot
    int m_v[3], m_tag[3], m_br[3], m_p[3], m_t[3];
    int m_ops[3][3];
    int seq = 0;
    bit prev_miss = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit st, input int rd, input int cp, input int wr,
                        input bit be, input bit bp, input bit bt);
        bit miss, etake, ev;
        @(negedge clk);
        in_valid = v; stall = st; in_rd_ops = rd[OW-1:0]; in_cp_ops = cp[OW-1:0];
        in_wr_ops = wr[OW-1:0]; in_br_en = be; in_br_pred = bp; in_br_taken = bt;
        #2;
        miss  = m_v[2] != 0 && m_br[2] != 0 && m_p[2] != m_t[2] && !st;
        etake = v && !st && !miss;
        chk("R2 take", int'(in_take), int'(etake));
        for (int k = 0; k < 3; k++) begin
            ev = m_v[k] != 0 && !st && !(k == 1 && miss);
            chk("R3 issue valid", int'(iss_vld[k]), int'(ev));
            if (ev) chk("R4 tag", int'(iss_tag[k]), m_tag[k]);
            chk("R10 ops", int'(iss_ops[k]), ev ? m_ops[k][k] : 0);
        end
        if (st) chk("R5 stall silent", int'({iss_vld, in_take}), 0);
        if (m_v[2] != 0 && m_br[2] != 0 && m_p[2] == m_t[2] && !st)
            chk("R6 good branch", int'(redirect), 0);
        chk("R7 redirect", int'(redirect), int'(miss));
        if (miss) begin
            chk("R7 writer kept", int'(iss_vld[2]), 1);
            chk("R8 cancel valid", int'(cxl_vld), (m_v[1] != 0 ? 2 : 0) + (m_v[0] != 0 ? 1 : 0));
            if (m_v[0] != 0) chk("R8 cancel tag0", int'(cxl_tag[0]), m_tag[0]);
            if (m_v[1] != 0) chk("R8 cancel tag1", int'(cxl_tag[1]), m_tag[1]);
        end else begin
            chk("R8 no cancel", int'(cxl_vld), 0);
        end
        if (prev_miss) chk("R9 bubble", int'(iss_vld), 0);
        // advance model at the coming edge
        if (!st) begin
            for (int k = 2; k >= 1; k--) begin
                m_v[k] = miss ? 0 : m_v[k-1];
                m_tag[k] = m_tag[k-1]; m_br[k] = m_br[k-1];
                m_p[k] = m_p[k-1]; m_t[k] = m_t[k-1];
                for (int g = 0; g < 3; g++) m_ops[k][g] = m_ops[k-1][g];
            end
            m_v[0] = etake ? 1 : 0;
            m_tag[0] = seq; m_br[0] = be; m_p[0] = bp; m_t[0] = bt;
            m_ops[0][0] = rd; m_ops[0][1] = cp; m_ops[0][2] = wr;
            if (etake) seq = (seq + 1) % (1 << TW);
        end
        prev_miss = miss;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        for (int k = 0; k < 3; k++) begin
            m_v[k] = 0; m_tag[k] = 0; m_br[k] = 0; m_p[k] = 0; m_t[k] = 0;
            for (int g = 0; g < 3; g++) m_ops[k][g] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        chk("R1 reset valids", int'(iss_vld), 0);
        chk("R1 reset redirect", int'(redirect), 0);
        chk("R1 reset cancel", int'(cxl_vld), 0);
        // plain stream: tag 0 first, wraps after 8 (R1, R4)
        for (int i = 0; i < 12; i++) step(1, 0, i % 8, (i + 3) % 8, (i + 5) % 8, 0, 0, 0);
        // correct prediction, then a stall landing on a branch in the last slot
        step(1, 0, 1, 2, 3, 1, 1, 1);
        step(1, 0, 4, 5, 6, 1, 0, 1);
        step(1, 0, 7, 0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 2, 2, 2, 0, 0, 0);
        step(1, 0, 3, 3, 3, 0, 0, 0);
        step(1, 0, 5, 5, 5, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // pseudo-random sweep
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[2:0] != 3'd0, lf[5:3] == 3'd0, int'(lf[8:6]), int'(lf[11:9]),
                 int'(lf[14:12]), lf[1:0] == 2'd3, lf[15], lf[7] ^ (lf[4] & lf[9]));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule